// File: doc/BRIEF.md
# Power-Mode Control Register Interlock

This block is one 8-bit control and status register in a microcontroller power manager. Software uses it to ask for the low-power regulator mode, to let interrupts end that mode, to lock or allow partial power-down, and to choose which stop mode the sleep sequencer enters. The register does not take written data as given. It applies fixed rules between the bits, so that the regulator-standby request and the stop2 selection are never active together. The partial power-down enable can be written only once after reset. A wake interrupt taken in a low-power mode clears the regulator request without any software action.

The register also holds a sticky flag that records recovery from stop2, and it mirrors the regulator's standby acknowledge so software can read it. The stop-mode select and the regulator request drive ports of their own, which go to the sequencer and the regulator. Bit positions are fixed because software decodes them. All state changes on the rising clock edge. Reads are combinational and gated by the read strobe.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is asserted, and right after it, every stored bit is 0. `reg_stby_req` and `stop2_sel` are 0, and a read returns 0x00 as long as the acknowledge input is low.
- R2: Bit 7 is the regulator request. A write sets it to wdata[7] unless another rule blocks it. Its stored value drives `reg_stby_req`.
- R3: The request is not set by a write that has wdata[0]=1, and it is not set while the stored bit 0 is 1. The request and `stop2_sel` are never 1 at the same time.
- R4: Bit 0 is the stop-mode select (1 = stop2, 0 = stop3) and drives `stop2_sel`. A write sets it to 1 only if bit 1 already holds 1 and the request already holds 0. A write with wdata[0]=0 always clears it.
- R5: Bit 1 is the partial power-down enable. The first write after reset loads it from wdata[1] and locks it. Later writes leave it unchanged.
- R6: Bit 5 is the wake-on-interrupt enable and is loaded by every write. When the stored enable is 1, `irq_pend`=1 and `lp_active`=1 in a cycle, the request is 0 after that edge. This clear wins over a write in the same cycle.
- R7: Read bit 6 shows `reg_stby_ack` as registered at the previous rising edge.
- R8: Bit 3 is the stop2-recovery flag. `stop2_recov`=1 sets it at the next edge. A write with wdata[2]=1 clears it. When both happen in the same cycle, the set wins.
- R9: Read bits 4 and 2 are always 0. When `rd_en`=0, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| irq_pend | input | 1 | An interrupt is pending |
| lp_active | input | 1 | The device is in a low-power mode |
| reg_stby_ack | input | 1 | The regulator reports standby |
| stop2_recov | input | 1 | Stop2 recovery event |
| reg_stby_req | output | 1 | Regulator standby request |
| stop2_sel | output | 1 | Stop mode select, 1 = stop2 |

## Verification
A write, a wake interrupt and a recovery event all take effect at the next rising edge. `reg_stby_req`, `stop2_sel` and the read data show the new value one edge after the stimulus, and the acknowledge mirror in bit 6 follows the same one-edge delay. The bench drives its inputs on falling edges. Its reference model steps on each rising edge and compares a quarter period later, so every comparison sees a settled result. Directed checks are sampled on the falling edge that follows the stimulus cycle. They cover the blocked request, the refused stop2 select, the write-once enable, the wake clear winning over a write, and the flag set winning over a clear.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int REG_W  = 8;
    localparam int B_RREQ = 7;
    localparam int B_STBY = 6;
    localparam int B_WAKE = 5;
    localparam int B_RSV  = 4;
    localparam int B_FLAG = 3;
    localparam int B_FCLR = 2;
    localparam int B_EN   = 1;
    localparam int B_SEL  = 0;

    typedef struct packed {
        logic rreq;
        logic wake;
        logic flag;
        logic en;
        logic lock;
        logic sel;
        logic stby;
    } pmc_state_t;
endpackage

// File: rtl/pmc_wr_filter.sv
module pmc_wr_filter (
    input  logic wr_en,
    input  logic w_rreq,
    input  logic w_wake,
    input  logic w_en,
    input  logic w_sel,
    input  logic rreq_q,
    input  logic wake_q,
    input  logic en_q,
    input  logic lock_q,
    input  logic sel_q,
    input  logic irq_pend,
    input  logic lp_active,
    output logic rreq_d,
    output logic wake_d,
    output logic en_d,
    output logic lock_d,
    output logic sel_d
);
    logic wake_hit;
    logic sel_ok;
    logic rreq_ok;

    always_comb begin
        wake_hit = wake_q & irq_pend & lp_active;
        sel_ok   = w_sel & en_q & ~rreq_q;
        rreq_ok  = w_rreq & ~w_sel & ~sel_q;

        rreq_d = rreq_q;
        wake_d = wake_q;
        en_d   = en_q;
        lock_d = lock_q;
        sel_d  = sel_q;

        if (wr_en) begin
            rreq_d = rreq_ok;
            wake_d = w_wake;
            sel_d  = sel_ok;
            lock_d = 1'b1;
            if (!lock_q) begin
                en_d = w_en;
            end
        end
        if (wake_hit) begin
            rreq_d = 1'b0;
        end
    end
endmodule

// File: rtl/pmc_flag_unit.sv
module pmc_flag_unit (
    input  logic wr_en,
    input  logic w_clr,
    input  logic recov,
    input  logic flag_q,
    output logic flag_d
);
    always_comb begin
        flag_d = flag_q;
        if (wr_en && w_clr) begin
            flag_d = 1'b0;
        end
        if (recov) begin
            flag_d = 1'b1;
        end
    end
endmodule

// File: rtl/pmc_read_mux.sv
module pmc_read_mux
    import pmc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         rd_en,
    input  logic         rreq_q,
    input  logic         stby_q,
    input  logic         wake_q,
    input  logic         flag_q,
    input  logic         en_q,
    input  logic         sel_q,
    output logic [W-1:0] rdata
);
    logic [W-1:0] image;

    always_comb begin
        image         = '0;
        image[B_RREQ] = rreq_q;
        image[B_STBY] = stby_q;
        image[B_WAKE] = wake_q;
        image[B_FLAG] = flag_q;
        image[B_EN]   = en_q;
        image[B_SEL]  = sel_q;
    end

    for (genvar i = 0; i < W; i++) begin : g_gate
        assign rdata[i] = rd_en & image[i];
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             irq_pend,
    input  logic             lp_active,
    input  logic             reg_stby_ack,
    input  logic             stop2_recov,
    output logic             reg_stby_req,
    output logic             stop2_sel
);
    pmc_state_t state_d, state_q;
    logic rreq_n, wake_n, en_n, lock_n, sel_n, flag_n;

    pmc_wr_filter u_filt (
        .wr_en     (wr_en),
        .w_rreq    (wdata[B_RREQ]),
        .w_wake    (wdata[B_WAKE]),
        .w_en      (wdata[B_EN]),
        .w_sel     (wdata[B_SEL]),
        .rreq_q    (state_q.rreq),
        .wake_q    (state_q.wake),
        .en_q      (state_q.en),
        .lock_q    (state_q.lock),
        .sel_q     (state_q.sel),
        .irq_pend  (irq_pend),
        .lp_active (lp_active),
        .rreq_d    (rreq_n),
        .wake_d    (wake_n),
        .en_d      (en_n),
        .lock_d    (lock_n),
        .sel_d     (sel_n)
    );

    pmc_flag_unit u_flag (
        .wr_en  (wr_en),
        .w_clr  (wdata[B_FCLR]),
        .recov  (stop2_recov),
        .flag_q (state_q.flag),
        .flag_d (flag_n)
    );

    pmc_read_mux #(.W(REG_W)) u_rd (
        .rd_en  (rd_en),
        .rreq_q (state_q.rreq),
        .stby_q (state_q.stby),
        .wake_q (state_q.wake),
        .flag_q (state_q.flag),
        .en_q   (state_q.en),
        .sel_q  (state_q.sel),
        .rdata  (rdata)
    );

    always_comb begin
        state_d      = state_q;
        state_d.rreq = rreq_n;
        state_d.wake = wake_n;
        state_d.en   = en_n;
        state_d.lock = lock_n;
        state_d.sel  = sel_n;
        state_d.flag = flag_n;
        state_d.stby = reg_stby_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_stby_req = state_q.rreq;
    assign stop2_sel    = state_q.sel;
endmodule

// File: rtl/pmc_checks.sv
module pmc_checks
    import pmc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             w_sel,
    input logic [REG_W-1:0] rdata,
    input logic             irq_pend,
    input logic             lp_active,
    input logic             reg_stby_ack,
    input logic             stop2_recov,
    input pmc_state_t       st
);
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st.rreq && st.sel));

    p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_sel) |=> !st.rreq);

    p_sel_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.sel) |-> $past(st.en));

    p_en_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st.lock |=> $stable(st.en));

    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st.wake && irq_pend && lp_active) |=> !st.rreq);

    p_stby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st.stby == $past(reg_stby_ack)));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop2_recov |=> st.flag);

    p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[B_RSV] == 1'b0) && (rdata[B_FCLR] == 1'b0));

    p_rd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

bind pwr_mode_ctl pmc_checks u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .w_sel        (wdata[0]),
    .rdata        (rdata),
    .irq_pend     (irq_pend),
    .lp_active    (lp_active),
    .reg_stby_ack (reg_stby_ack),
    .stop2_recov  (stop2_recov),
    .st           (state_q)
);

// File: tb/pwr_mode_ctl_test.sv
module pwr_mode_ctl_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_pend = 1'b0;
    logic       lp_active = 1'b0;
    logic       reg_stby_ack = 1'b0;
    logic       stop2_recov = 1'b0;
    logic       reg_stby_req;
    logic       stop2_sel;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model state
    bit m_req, m_wake, m_flag, m_en, m_lock, m_sel, m_stby;

    always #(CLK_P/2) clk = ~clk;

    pwr_mode_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_pend(irq_pend),
        .lp_active(lp_active), .reg_stby_ack(reg_stby_ack),
        .stop2_recov(stop2_recov), .reg_stby_req(reg_stby_req),
        .stop2_sel(stop2_sel)
    );

    function automatic logic [7:0] model_read();
        logic [7:0] v;
        v = 8'h00;
        if (rd_en) begin
            v = {m_req, m_stby, m_wake, 1'b0, m_flag, 1'b0, m_en, m_sel};
        end
        return v;
    endfunction

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // reference model: steps on each edge, compared a quarter period later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_req, m_wake, m_flag, m_en, m_lock, m_sel, m_stby} = '0;
        end else begin
            bit nreq, nsel, nflag;
            cyc++;
            nreq = m_req;
            nsel = m_sel;
            nflag = m_flag;
            if (wr_en) begin
                nsel = wdata[0] && m_en && !m_req;
                nreq = wdata[7] && !wdata[0] && !m_sel;
                m_wake = wdata[5];
                if (!m_lock) m_en = wdata[1];
                m_lock = 1'b1;
                if (wdata[2]) nflag = 1'b0;
            end
            if (stop2_recov) nflag = 1'b1;
            if (m_wake_prev_hit()) nreq = 1'b0;
            m_req = nreq;
            m_sel = nsel;
            m_flag = nflag;
            m_stby = reg_stby_ack;
            #(CLK_P/4);
            chk(rdata, model_read(), "R9 read image");
            chk({7'b0, reg_stby_req}, {7'b0, m_req}, "R2 request port");
            chk({7'b0, stop2_sel}, {7'b0, m_sel}, "R4 select port");
        end
    end

    // wake condition uses the enable held before this edge
    bit wake_before;
    always @(negedge clk) wake_before = m_wake;
    function automatic bit m_wake_prev_hit();
        return wake_before && irq_pend && lp_active;
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rdata, 8'h00, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata, 8'h00, "R1 after reset");
        chk({6'b0, reg_stby_req, stop2_sel}, 8'h00, "R1 ports");

        // enable locked at 0 by the first write
        wr(8'hA1);
        chk(rdata, 8'h20, "R3 request with bit0 written");
        wr(8'h82);
        chk(rdata, 8'h80, "R5 enable ignored after lock");
        wr(8'h03);
        chk(rdata, 8'h00, "R4 select refused without enable");
        chk({7'b0, stop2_sel}, 8'h00, "R4 select port low");

        do_reset();
        @(negedge clk);
        chk(rdata, 8'h00, "R1 second reset");
        wr(8'h02);
        chk(rdata, 8'h02, "R5 first write loads enable");
        wr(8'h01);
        chk(rdata, 8'h03, "R4 select set with enable");
        chk({7'b0, stop2_sel}, 8'h01, "R4 select port high");
        wr(8'h80);
        chk(rdata, 8'h02, "R3 request blocked by stored select");
        wr(8'h80);
        chk(rdata, 8'h82, "R2 request set");
        chk({7'b0, reg_stby_req}, 8'h01, "R2 request port high");
        wr(8'h01);
        chk(rdata, 8'h02, "R4 select refused while request held");
        wr(8'hA0);
        chk(rdata, 8'hA2, "R6 wake enable set");

        @(negedge clk); irq_pend = 1'b1; lp_active = 1'b0;
        @(negedge clk); irq_pend = 1'b0;
        chk(rdata, 8'hA2, "R6 no clear outside low power");
        @(negedge clk); irq_pend = 1'b1; lp_active = 1'b1;
        @(negedge clk); irq_pend = 1'b0; lp_active = 1'b0;
        chk(rdata, 8'h22, "R6 wake clears request");

        wr(8'hA0);
        @(negedge clk); wr_en = 1'b1; wdata = 8'hA0; irq_pend = 1'b1; lp_active = 1'b1;
        @(negedge clk); wr_en = 1'b0; wdata = 8'h00; irq_pend = 1'b0; lp_active = 1'b0;
        chk(rdata, 8'h22, "R6 wake beats write");

        wr(8'h80);
        @(negedge clk); irq_pend = 1'b1; lp_active = 1'b1;
        @(negedge clk); irq_pend = 1'b0; lp_active = 1'b0;
        chk(rdata, 8'h82, "R6 request kept with wake disabled");

        @(negedge clk); stop2_recov = 1'b1;
        @(negedge clk); stop2_recov = 1'b0;
        chk(rdata, 8'h8A, "R8 flag set");
        wr(8'h84);
        chk(rdata, 8'h82, "R8 flag cleared by write");
        @(negedge clk); wr_en = 1'b1; wdata = 8'h84; stop2_recov = 1'b1;
        @(negedge clk); wr_en = 1'b0; wdata = 8'h00; stop2_recov = 1'b0;
        chk(rdata, 8'h8A, "R8 set beats clear");
        chk(rdata & 8'h14, 8'h00, "R9 reserved bits zero");

        @(negedge clk); reg_stby_ack = 1'b1;
        chk(rdata, 8'h8A, "R7 mirror not yet updated");
        @(negedge clk);
        chk(rdata, 8'hCA, "R7 mirror follows acknowledge");
        reg_stby_ack = 1'b0;
        @(negedge clk);
        chk(rdata, 8'h8A, "R7 mirror falls");

        rd_en = 1'b0;
        @(negedge clk);
        chk(rdata, 8'h00, "R9 read strobe low");
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule